// File: doc/BRIEF.md
# Raster-Synchronised Programmable Timer with Interrupt Latching

This block is a down-counting timer tied to the video raster. The CPU writes a 32-bit reload value as two 16-bit halves and sets a mode word. The mode word chooses when the counter is reloaded, whether expiry raises an interrupt, and whether the system runs at 50 Hz. The counter steps once on each pixel-clock enable. When it runs out, it can raise a timer interrupt and can reload itself.

Three interrupt sources are kept as pending flags: timer expiry, a vertical-blank strobe and an external third source. A flag stays set until software clears it with a byte write to the acknowledge register. In 50 Hz operation an optional stop bit holds the counter still during the first 32 raster lines after each frame start. A status word reports the current raster line and the 50/60 Hz setting.

Top module: `raster_timer`

## Requirements
- R1: After reset all three interrupt outputs are 0, the counter is 0, every mode bit and the stop bit are 0, and the status word shows 0 in its 50 Hz bit.
- R2: A write to address 4 stores the upper 16 bits of the reload value, and a write to address 5 stores the lower 16 bits. When mode bit 0 is 1, a write to address 5 also loads the counter at once with {upper half, written data}.
- R3: Each cycle with `pix_ce` high, the counter decreases by one if it is not zero and not frozen. The step from 1 to 0 is an expiry. An expiry sets the timer pending flag only when mode bit 3 (interrupt enable) is 1.
- R4: When mode bit 2 is 1, an expiry loads the reload value in place of zero, so expiries repeat every reload-value ticks.
- R5: When mode bit 1 is 1, a `frame_strobe` loads the counter from the reload value.
- R6: When mode bit 2 is 0, the counter stays at zero after an expiry and produces no further expiry.
- R7: A `vblank_strobe` sets the vertical-blank pending flag and an `ext_strobe` sets the external pending flag. Each flag holds until it is acknowledged.
- R8: A write to address 6 acknowledges flags using data bits 7:0. Bit 2 clears vertical blank, bit 1 clears the timer flag and bit 0 clears the external flag. A flag whose bit is 0 is left unchanged.
- R9: If a set event and an acknowledge of the same flag occur in the same cycle, the flag is set afterwards.
- R10: When stop bit 0 (written at address 7) is 1 and mode bit 4 (50 Hz) is 1, the counter does not step. This lasts from a `frame_strobe` until 32 `line_strobe` pulses have been seen.
- R11: When mode bit 4 is 0, the stop bit has no effect on counting.
- R12: `status` shows `raster_line` in bits 15:7 and mode bit 4 in bit 3. Every other bit is 0.
- R13: Loads have a fixed priority. A load from a low-half write wins over a frame reload, and a frame reload wins over a pixel step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-clock enable, one counter step |
| line_strobe | input | 1 | One-cycle pulse per raster line |
| frame_strobe | input | 1 | One-cycle pulse at frame start |
| vblank_strobe | input | 1 | Vertical-blank event |
| ext_strobe | input | 1 | Third interrupt source event |
| raster_line | input | 9 | Current raster line number |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data (acknowledge uses bits 7:0) |
| irq_vblank | output | 1 | Vertical-blank pending |
| irq_timer | output | 1 | Timer pending |
| irq_ext | output | 1 | External pending |
| status | output | 16 | Raster line and 50 Hz flag |

## Verification
The assertions assume that every strobe and write lasts one cycle. They also assume that the stepping checks apply only in cycles where no load of higher priority is pending, and they state that condition explicitly. The stimulus drives each event from a task as a single-cycle pulse on the falling edge. It never overlaps a write with another write. It combines two events in one cycle only where R9 and R13 require it.

// File: rtl/raster_timer_pkg.sv
package raster_timer_pkg;

    localparam int unsigned HALF_W = 16;
    localparam int unsigned CNT_W  = 2 * HALF_W;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned N_SRC  = 3;

    localparam logic [ADDR_W-1:0] A_MODE      = 3'd3;
    localparam logic [ADDR_W-1:0] A_RELOAD_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_RELOAD_LO = 3'd5;
    localparam logic [ADDR_W-1:0] A_ACK       = 3'd6;
    localparam logic [ADDR_W-1:0] A_STOP      = 3'd7;

    // pending flag positions, matching the acknowledge byte
    localparam int unsigned SRC_EXT = 0;
    localparam int unsigned SRC_TMR = 1;
    localparam int unsigned SRC_VBL = 2;

    // mode word, bit 0 at the right
    typedef struct packed {
        logic pal;
        logic irq_en;
        logic reload_on_zero;
        logic reload_on_frame;
        logic load_on_write;
    } mode_t;

endpackage

// File: rtl/raster_timer_regs.sv
module raster_timer_regs
    import raster_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [HALF_W-1:0] wr_data_i,
    output mode_t             mode_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              stop_o,
    output logic              load_now_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic [N_SRC-1:0]  ack_o
);

    typedef struct packed {
        mode_t             mode;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic              stop;
    } regs_t;

    regs_t q, d;
    localparam int unsigned MODE_W = $bits(mode_t);

    always_comb begin
        d          = q;
        load_now_o = 1'b0;
        ack_o      = '0;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_MODE:      d.mode = mode_t'(wr_data_i[MODE_W-1:0]);
                A_RELOAD_HI: d.hi   = wr_data_i;
                A_RELOAD_LO: begin
                    d.lo       = wr_data_i;
                    load_now_o = q.mode.load_on_write;
                end
                A_ACK:       ack_o  = wr_data_i[N_SRC-1:0];
                A_STOP:      d.stop = wr_data_i[0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode_o     = q.mode;
    assign reload_o   = {q.hi, q.lo};
    assign stop_o     = q.stop;
    assign load_val_o = {q.hi, wr_data_i};

    p_reload_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_RELOAD_LO) |=> (reload_o[HALF_W-1:0] == $past(wr_data_i)));

    p_reload_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_RELOAD_HI) |=> (reload_o[CNT_W-1:HALF_W] == $past(wr_data_i)));

endmodule

// File: rtl/raster_timer_count.sv
module raster_timer_count
    import raster_timer_pkg::*;
#(
    parameter int unsigned FREEZE_LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ce_i,
    input  logic             line_strobe_i,
    input  logic             frame_strobe_i,
    input  mode_t            mode_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             load_now_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);

    localparam int unsigned FW = $clog2(FREEZE_LINES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [FW-1:0]    freeze;
    } cnt_t;

    cnt_t q, d;
    logic frozen;
    logic frame_load;

    assign frozen     = stop_i && mode_i.pal && (q.freeze != '0);
    assign frame_load = frame_strobe_i && mode_i.reload_on_frame;

    always_comb begin
        d        = q;
        expire_o = 1'b0;
        if (frame_strobe_i)
            d.freeze = FW'(FREEZE_LINES);
        else if (line_strobe_i && q.freeze != '0)
            d.freeze = q.freeze - 1'b1;

        if (load_now_i)
            d.cnt = load_val_i;
        else if (frame_load)
            d.cnt = reload_i;
        else if (pix_ce_i && !frozen && q.cnt != '0) begin
            if (q.cnt == CNT_W'(1)) begin
                expire_o = 1'b1;
                d.cnt    = mode_i.reload_on_zero ? reload_i : '0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic [CNT_W-1:0] cnt_q;
    assign cnt_q = q.cnt;

    p_expire_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> (pix_ce_i && !frozen && !load_now_i));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce_i && !frozen && !load_now_i && !frame_load && cnt_q > CNT_W'(1))
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !load_now_i && !frame_load) |=> $stable(cnt_q));

    p_load_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
        load_now_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/raster_timer_pend.sv
module raster_timer_pend
    import raster_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [N_SRC-1:0] pend;
    } pend_t;

    pend_t q, d;

    always_comb begin
        d      = q;
        d.pend = (q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o = q.pend;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_o[i]);
        p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
    end

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_timer_pkg::*;
#(
    parameter int unsigned LINE_W       = 9,
    parameter int unsigned FREEZE_LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ce,
    input  logic              line_strobe,
    input  logic              frame_strobe,
    input  logic              vblank_strobe,
    input  logic              ext_strobe,
    input  logic [LINE_W-1:0] raster_line,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [15:0]       wr_data,
    output logic              irq_vblank,
    output logic              irq_timer,
    output logic              irq_ext,
    output logic [15:0]       status
);

    localparam int unsigned PAD_W = HALF_W - LINE_W - 4;

    mode_t            mode;
    logic [CNT_W-1:0] reload;
    logic             stop;
    logic             load_now;
    logic [CNT_W-1:0] load_val;
    logic [N_SRC-1:0] ack;
    logic             expire;
    logic [N_SRC-1:0] set;
    logic [N_SRC-1:0] pend;

    raster_timer_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .mode_o     (mode),
        .reload_o   (reload),
        .stop_o     (stop),
        .load_now_o (load_now),
        .load_val_o (load_val),
        .ack_o      (ack)
    );

    raster_timer_count #(.FREEZE_LINES(FREEZE_LINES)) i_count (
        .clk            (clk),
        .rst_n          (rst_n),
        .pix_ce_i       (pix_ce),
        .line_strobe_i  (line_strobe),
        .frame_strobe_i (frame_strobe),
        .mode_i         (mode),
        .stop_i         (stop),
        .reload_i       (reload),
        .load_now_i     (load_now),
        .load_val_i     (load_val),
        .expire_o       (expire)
    );

    always_comb begin
        set          = '0;
        set[SRC_EXT] = ext_strobe;
        set[SRC_TMR] = expire && mode.irq_en;
        set[SRC_VBL] = vblank_strobe;
    end

    raster_timer_pend i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set),
        .clr_i  (ack),
        .pend_o (pend)
    );

    assign irq_vblank = pend[SRC_VBL];
    assign irq_timer  = pend[SRC_TMR];
    assign irq_ext    = pend[SRC_EXT];
    assign status     = {raster_line, {PAD_W{1'b0}}, mode.pal, 3'b000};

    p_timer_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_timer && !mode.irq_en) |=> !irq_timer);

endmodule

// File: tb/test_raster_timer.sv
`timescale 1ns/1ps
module test_raster_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b0, line_strobe = 1'b0, frame_strobe = 1'b0;
    logic        vblank_strobe = 1'b0, ext_strobe = 1'b0;
    logic [8:0]  raster_line = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        irq_vblank, irq_timer, irq_ext;
    logic [15:0] status;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    raster_timer i_raster_timer (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .line_strobe(line_strobe),
        .frame_strobe(frame_strobe), .vblank_strobe(vblank_strobe),
        .ext_strobe(ext_strobe), .raster_line(raster_line), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq_vblank(irq_vblank),
        .irq_timer(irq_timer), .irq_ext(irq_ext), .status(status)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] dt);
        wr_en = 1'b1; wr_addr = a; wr_data = dt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        if (n > 0) begin
            pix_ce = 1'b1;
            repeat (n) @(negedge clk);
            pix_ce = 1'b0;
        end
    endtask

    task automatic frame();
        frame_strobe = 1'b1; @(negedge clk); frame_strobe = 1'b0;
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin
            line_strobe = 1'b1; @(negedge clk); line_strobe = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1 timer", {15'd0, irq_timer}, 16'd0);
        check("R1 vblank", {15'd0, irq_vblank}, 16'd0);
        check("R1 ext", {15'd0, irq_ext}, 16'd0);
        check("R1 status", status, 16'd0);
        tick(5);
        check("R1 counter idle", {15'd0, irq_timer}, 16'd0);
    endtask

    task automatic t_oneshot();
        wr(3'd3, 16'h0009);
        wr(3'd4, 16'h0000);
        wr(3'd5, 16'd5);
        tick(4);
        check("R3 before expiry", {15'd0, irq_timer}, 16'd0);
        tick(1);
        check("R3 expiry", {15'd0, irq_timer}, 16'd1);
        wr(3'd6, 16'h0002);
        check("R8 timer ack", {15'd0, irq_timer}, 16'd0);
        tick(10);
        check("R6 no repeat", {15'd0, irq_timer}, 16'd0);
    endtask

    task automatic t_disabled();
        wr(3'd3, 16'h0001);
        wr(3'd5, 16'd3);
        tick(3);
        check("R3 enable off", {15'd0, irq_timer}, 16'd0);
    endtask

    task automatic t_high_half();
        wr(3'd3, 16'h0009);
        wr(3'd4, 16'h0001);
        wr(3'd5, 16'h0000);
        tick(65535);
        check("R2 upper half pending", {15'd0, irq_timer}, 16'd0);
        tick(1);
        check("R2 upper half expiry", {15'd0, irq_timer}, 16'd1);
        wr(3'd6, 16'h0002);
        wr(3'd4, 16'h0000);
    endtask

    task automatic t_auto();
        wr(3'd3, 16'h000D);
        wr(3'd5, 16'd3);
        tick(3);
        check("R4 first expiry", {15'd0, irq_timer}, 16'd1);
        wr(3'd6, 16'h0002);
        tick(2);
        check("R4 mid period", {15'd0, irq_timer}, 16'd0);
        tick(1);
        check("R4 second expiry", {15'd0, irq_timer}, 16'd1);
        wr(3'd6, 16'h0002);
    endtask

    task automatic t_frame_reload();
        wr(3'd3, 16'h0008);
        wr(3'd5, 16'd4);
        wr(3'd3, 16'h000A);
        frame();
        tick(3);
        check("R5 before expiry", {15'd0, irq_timer}, 16'd0);
        tick(1);
        check("R5 expiry", {15'd0, irq_timer}, 16'd1);
        wr(3'd6, 16'h0002);
    endtask

    task automatic t_priority();
        wr(3'd3, 16'h000B);
        wr(3'd5, 16'd6);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 16'd2; frame_strobe = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; frame_strobe = 1'b0;
        tick(1);
        check("R13 write load wins", {15'd0, irq_timer}, 16'd0);
        tick(1);
        check("R13 write load wins expiry", {15'd0, irq_timer}, 16'd1);
        wr(3'd6, 16'h0002);
    endtask

    task automatic t_freeze();
        wr(3'd3, 16'h0019);
        wr(3'd7, 16'h0001);
        wr(3'd5, 16'd3);
        frame();
        tick(5);
        check("R10 frozen", {15'd0, irq_timer}, 16'd0);
        lines(31);
        tick(3);
        check("R10 frozen line 31", {15'd0, irq_timer}, 16'd0);
        lines(1);
        tick(2);
        check("R10 thawed partial", {15'd0, irq_timer}, 16'd0);
        tick(1);
        check("R10 thawed expiry", {15'd0, irq_timer}, 16'd1);
        wr(3'd6, 16'h0002);
    endtask

    task automatic t_no_pal();
        wr(3'd3, 16'h0009);
        wr(3'd5, 16'd3);
        frame();
        tick(3);
        check("R11 stop ignored", {15'd0, irq_timer}, 16'd1);
        wr(3'd6, 16'h0002);
        wr(3'd7, 16'h0000);
    endtask

    task automatic t_sources();
        vblank_strobe = 1'b1; @(negedge clk); vblank_strobe = 1'b0;
        ext_strobe = 1'b1; @(negedge clk); ext_strobe = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 vblank held", {15'd0, irq_vblank}, 16'd1);
        check("R7 ext held", {15'd0, irq_ext}, 16'd1);
        wr(3'd6, 16'h0004);
        check("R8 vblank cleared", {15'd0, irq_vblank}, 16'd0);
        check("R8 ext kept", {15'd0, irq_ext}, 16'd1);
        wr(3'd6, 16'h0001);
        check("R8 ext cleared", {15'd0, irq_ext}, 16'd0);
        vblank_strobe = 1'b1; wr_en = 1'b1; wr_addr = 3'd6; wr_data = 16'h0004;
        @(negedge clk);
        vblank_strobe = 1'b0; wr_en = 1'b0;
        check("R9 set beats ack", {15'd0, irq_vblank}, 16'd1);
        wr(3'd6, 16'h0007);
        check("R8 all cleared", {13'd0, irq_vblank, irq_timer, irq_ext}, 16'd0);
    endtask

    task automatic t_status();
        raster_line = 9'h1A5;
        wr(3'd3, 16'h0010);
        check("R12 status pal", status, {9'h1A5, 3'b000, 1'b1, 3'b000});
        raster_line = 9'h003;
        wr(3'd3, 16'h0000);
        check("R12 status ntsc", status, {9'h003, 3'b000, 1'b0, 3'b000});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_disabled();
        t_high_half();
        t_auto();
        t_frame_reload();
        t_priority();
        t_freeze();
        t_no_pal();
        t_sources();
        t_status();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule